// File: doc/BRIEF.md
# Dual 16-bit Timer/Counter

This block holds two independent 16-bit timer/counters that software drives through a small byte-wide register bus. Each timer has a low count byte and a high count byte. A shared mode register gives each timer a 4-bit nibble that selects the following:
- a gating option;
- the count source: a free-running divide-by-12 clock enable, or falling edges on that timer's external count pin;
- one of four counting structures.

A control register holds the run bits and the overflow flags of both timers.

When a timer overflows, its flag is set and a one-cycle pulse goes to the interrupt controller. The interrupt controller clears the flag again with an acknowledge pulse. Every overflow of timer 1 also produces a one-cycle tick, which a serial-port baud generator uses as its clock. In the split mode, timer 0 becomes two 8-bit timers. Its high half then takes over timer 1's run bit and overflow flag, and timer 1 is frozen.

The external count and gate pins are sampled on every clock by one register stage. A falling edge is found by comparing that sample with the sample from the clock before.

Top module: `dual_tmr_ctr`

## Requirements
- R1: After reset, the following all read 0x00: both timers' count bytes, the mode register and the control register. The outputs ovf_irq and baud_tick are low.
- R2: Register addresses:
  - 0: timer 0 low byte
  - 1: timer 0 high byte
  - 2: timer 1 low byte
  - 3: timer 1 high byte
  - 4: mode register
  - 5: control register

  A write stores the data byte, and a later read returns it. When sfr_re is low, or the address is 6 or 7, sfr_rdata is 0x00.
- R3: Control register bits: bit0 = run 0, bit1 = flag 0, bit2 = run 1, bit3 = flag 1. Bits 7:4 read 0. Mode register: timer 0 uses bits 3:0 and timer 1 uses bits 7:4. In each nibble, bit3 = gate, bit2 = count-source select (1 = pin edges, 0 = prescaled clock), bits1:0 = mode. With the prescaled source, a running timer advances exactly once in every 12 consecutive clock cycles.
- R4: With the pin source, the count advances once for each falling edge on that timer's cnt_pin bit. The new value is visible two clock edges after the pin falls.
- R5: A timer counts only when its run bit is 1 and either its gate bit is 0 or its gate_pin bit is 1. Otherwise the count holds.
- R6: Mode 00 is a 13-bit counter. The high byte holds the upper 8 bits and low-byte bits 4:0 hold the lower 5 bits. Low-byte bits 7:5 keep their written value. The counter overflows when it passes from all ones to zero.
- R7: Mode 01 is a 16-bit counter made of {high, low}. It overflows from 0xFFFF to 0x0000.
- R8: Mode 10 counts only in the low byte. When the low byte is 0xFF, the next step reloads it from the high byte and counts as an overflow. The high byte does not change.
- R9: Mode 11 applies in two ways:
  - For timer 0, the low byte becomes an 8-bit counter under run 0, gate and source, and it sets flag 0. The high byte becomes an 8-bit prescaled timer under run 1 only, and it sets flag 1.
  - For timer 1, mode 11 freezes the count and gives no overflow or baud_tick.
- R10: An overflow sets the timer's flag. In the same cycle, that timer's ovf_irq bit pulses high for one clock. Every overflow of timer 1 gives a one-clock baud_tick pulse.
- R11: A flag is cleared by a control-register write of 0 to it, or by a one-cycle pulse on its own flag_ack bit. The other flag is unaffected. An overflow in the same cycle as an acknowledge sets the flag. A control-register write in the same cycle as an overflow sets the flag to the written value.
- R12: A write to either count byte of a timer in the same cycle as an increment stores the written byte. That increment is dropped, and no carry reaches the other byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sfr_addr | input | AW (3) | Register address |
| sfr_wdata | input | 8 | Write data |
| sfr_we | input | 1 | Write strobe |
| sfr_re | input | 1 | Read enable; sfr_rdata is zero when low |
| sfr_rdata | output | 8 | Read data, combinational from the address |
| cnt_pin | input | 2 | External count inputs, bit i for timer i |
| gate_pin | input | 2 | External gate inputs, bit i for timer i |
| flag_ack | input | 2 | Flag clear pulses from the interrupt controller |
| ovf_irq | output | 2 | One-cycle pulse when flag i is set by an overflow |
| baud_tick | output | 1 | One-cycle pulse on each timer 1 overflow |

## Verification
The hardest case to reach from the ports is R12, where a software write to a count byte falls in the same cycle as an increment. The prescaler phase is not visible, so the bench uses the pin source instead. It drops cnt_pin at a known falling clock edge, then pulses the write strobe in exactly the cycle where the detected edge would increment. It preloads 0x00FF so that a leaked increment would also carry into the high byte. The mode 11 overflow of timer 0's high half is the other hard case. The bench reaches it by preloading that half with 0xFF and running only run 1. It then reads flag 1 while timer 1, frozen in the same mode, keeps its preload.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADR_T0_LO = 0;
  localparam int ADR_T0_HI = 1;
  localparam int ADR_T1_LO = 2;
  localparam int ADR_T1_HI = 3;
  localparam int ADR_MODE  = 4;
  localparam int ADR_CTRL  = 5;

  typedef enum logic [1:0] {
    M_13BIT   = 2'b00,
    M_16BIT   = 2'b01,
    M_RELOAD8 = 2'b10,
    M_SPLIT   = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext;
    tmr_mode_e mode;
  } tmr_cfg_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_n;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_comb begin
    cnt_n = tick ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int W      = 4,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] level
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign level = stg_q[STAGES-1];
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter bit SPLIT_OK = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  tmr_mode_e   mode,
  input  logic        inc,
  input  logic        inc_hi,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [7:0]  wdata,
  output logic [15:0] cnt,
  output logic        ov_a,
  output logic        ov_b
);
  logic [7:0]  lo_q, hi_q, lo_n, hi_n;
  logic [13:0] sum13;
  logic [16:0] sum16;
  logic        wr_any;

  assign wr_any = wr_lo | wr_hi;
  assign cnt    = {hi_q, lo_q};

  always_comb begin
    lo_n  = lo_q;
    hi_n  = hi_q;
    ov_a  = 1'b0;
    ov_b  = 1'b0;
    sum13 = {1'b0, hi_q, lo_q[4:0]} + 14'd1;
    sum16 = {1'b0, hi_q, lo_q} + 17'd1;
    case (mode)
      M_13BIT: if (inc && !wr_any) begin
        hi_n = sum13[12:5];
        lo_n = {lo_q[7:5], sum13[4:0]};
        ov_a = sum13[13];
      end
      M_16BIT: if (inc && !wr_any) begin
        {hi_n, lo_n} = sum16[15:0];
        ov_a = sum16[16];
      end
      M_RELOAD8: if (inc && !wr_any) begin
        if (&lo_q) begin
          lo_n = hi_q;
          ov_a = 1'b1;
        end else begin
          lo_n = lo_q + 8'd1;
        end
      end
      default: if (SPLIT_OK) begin
        if (inc && !wr_lo) begin
          lo_n = lo_q + 8'd1;
          ov_a = &lo_q;
        end
        if (inc_hi && !wr_hi) begin
          hi_n = hi_q + 8'd1;
          ov_b = &hi_q;
        end
      end
    endcase
    if (wr_lo) lo_n = wdata;
    if (wr_hi) hi_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end
endmodule

// File: rtl/dual_tmr_ctr.sv
module dual_tmr_ctr
  import tmr_pkg::*;
#(
  parameter int AW          = 3,
  parameter int DIV         = 12,
  parameter int SYNC_STAGES = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] sfr_addr,
  input  logic [7:0]    sfr_wdata,
  input  logic          sfr_we,
  input  logic          sfr_re,
  output logic [7:0]    sfr_rdata,
  input  logic [1:0]    cnt_pin,
  input  logic [1:0]    gate_pin,
  input  logic [1:0]    flag_ack,
  output logic [1:0]    ovf_irq,
  output logic          baud_tick
);
  localparam int NT = 2;

  logic [1:0]    rs_q;
  logic          rst_q_n;
  logic          tick;
  logic [3:0]    pin_lvl;
  logic [NT-1:0] cnt_lvl, gate_lvl, prev_q, fall;
  logic [7:0]    mode_q, mode_n;
  logic [NT-1:0] run_q, run_n, flag_q, flag_n, irq_q, set;
  logic          baud_q;
  logic [NT-1:0] wr_lo, wr_hi, open, inc, inc_hi, ov_a, ov_b;
  logic          wr_mode, wr_ctrl;
  tmr_cfg_t      cfg  [NT];
  logic [15:0]   tcnt [NT];

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q_n = rs_q[1];

  tmr_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_q_n), .tick(tick)
  );

  tmr_pin_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q_n), .din({gate_pin, cnt_pin}), .level(pin_lvl)
  );
  assign cnt_lvl  = pin_lvl[1:0];
  assign gate_lvl = pin_lvl[3:2];
  assign fall     = prev_q & ~cnt_lvl;

  // register decode
  always_comb begin
    wr_lo[0] = sfr_we && (sfr_addr == AW'(ADR_T0_LO));
    wr_hi[0] = sfr_we && (sfr_addr == AW'(ADR_T0_HI));
    wr_lo[1] = sfr_we && (sfr_addr == AW'(ADR_T1_LO));
    wr_hi[1] = sfr_we && (sfr_addr == AW'(ADR_T1_HI));
    wr_mode  = sfr_we && (sfr_addr == AW'(ADR_MODE));
    wr_ctrl  = sfr_we && (sfr_addr == AW'(ADR_CTRL));
  end

  // count enables
  always_comb begin
    for (int i = 0; i < NT; i++) begin
      cfg[i]  = tmr_cfg_t'(mode_q[4*i +: 4]);
      open[i] = run_q[i] & (~cfg[i].gate | gate_lvl[i]);
      inc[i]  = open[i] & (cfg[i].ext ? fall[i] : tick);
    end
    inc_hi[0] = run_q[1] & tick;
    inc_hi[1] = 1'b0;
  end

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    tmr_core #(.SPLIT_OK(i == 0)) u_core (
      .clk(clk), .rst_n(rst_q_n), .mode(cfg[i].mode),
      .inc(inc[i]), .inc_hi(inc_hi[i]),
      .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(sfr_wdata),
      .cnt(tcnt[i]), .ov_a(ov_a[i]), .ov_b(ov_b[i])
    );
  end

  // flag sources and control next state
  always_comb begin
    set[0] = ov_a[0];
    set[1] = (cfg[0].mode == M_SPLIT) ? ov_b[0] : (ov_a[1] | ov_b[1]);
    run_n  = run_q;
    flag_n = flag_q;
    mode_n = wr_mode ? sfr_wdata : mode_q;
    for (int i = 0; i < NT; i++) begin
      if (set[i])           flag_n[i] = 1'b1;
      else if (flag_ack[i]) flag_n[i] = 1'b0;
    end
    if (wr_ctrl) begin
      run_n  = {sfr_wdata[2], sfr_wdata[0]};
      flag_n = {sfr_wdata[3], sfr_wdata[1]};
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      prev_q <= '0;
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
      irq_q  <= '0;
      baud_q <= 1'b0;
    end else begin
      prev_q <= cnt_lvl;
      mode_q <= mode_n;
      run_q  <= run_n;
      flag_q <= flag_n;
      irq_q  <= set;
      baud_q <= ov_a[1];
    end
  end

  assign ovf_irq   = irq_q;
  assign baud_tick = baud_q;

  // read mux
  always_comb begin
    sfr_rdata = 8'h00;
    if (sfr_re) begin
      case (sfr_addr)
        AW'(ADR_T0_LO): sfr_rdata = tcnt[0][7:0];
        AW'(ADR_T0_HI): sfr_rdata = tcnt[0][15:8];
        AW'(ADR_T1_LO): sfr_rdata = tcnt[1][7:0];
        AW'(ADR_T1_HI): sfr_rdata = tcnt[1][15:8];
        AW'(ADR_MODE):  sfr_rdata = mode_q;
        AW'(ADR_CTRL):  sfr_rdata = {4'h0, flag_q[1], run_q[1], flag_q[0], run_q[0]};
        default:        sfr_rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/dual_tmr_ctr_chk.sv
module dual_tmr_ctr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  ovf_irq,
  input logic        baud_tick,
  input logic [1:0]  flag_ack,
  input logic [1:0]  flag_q,
  input logic [1:0]  run_q,
  input logic [7:0]  mode_q,
  input logic        wr_ctrl,
  input logic        wr_t0,
  input logic        wr_t1,
  input logic [15:0] t0_cnt,
  input logic [15:0] t1_cnt
);
  AST_IRQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_irq[0] && !$past(wr_ctrl)) |-> flag_q[0]); // R10

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq[0] |=> !ovf_irq[0]); // R10

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_ack[0]) && !ovf_irq[0] && !$past(wr_ctrl)) |-> !flag_q[0]); // R11

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run_q[0] && !wr_t0 && (mode_q[1:0] != 2'b11)) |-> $stable(t0_cnt)); // R5

  AST_SPLIT_T1_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past((mode_q[5:4] == 2'b11) && !wr_t1) |-> $stable(t1_cnt)); // R9

  AST_SPLIT_NO_BAUD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_q[5:4] == 2'b11) |-> !baud_tick); // R9
endmodule

bind dual_tmr_ctr dual_tmr_ctr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ovf_irq(ovf_irq), .baud_tick(baud_tick),
  .flag_ack(flag_ack), .flag_q(flag_q), .run_q(run_q), .mode_q(mode_q),
  .wr_ctrl(wr_ctrl), .wr_t0(wr_lo[0] | wr_hi[0]), .wr_t1(wr_lo[1] | wr_hi[1]),
  .t0_cnt(tcnt[0]), .t1_cnt(tcnt[1])
);

// File: tb/sim_dual_tmr_ctr.sv
module sim_dual_tmr_ctr;
  localparam logic [2:0] A_T0L = 3'd0, A_T0H = 3'd1, A_T1L = 3'd2,
                         A_T1H = 3'd3, A_MODE = 3'd4, A_CTRL = 3'd5;

  typedef struct packed {
    logic [7:0] mode, lo, hi, n, elo, ehi;
    logic       eflag;
  } vec_t;

  // counter-source vectors on timer 0: mode, preload lo/hi, falls, expected lo/hi, flag
  localparam vec_t VECS [6] = '{
    '{8'h05, 8'hFE, 8'h00, 8'd3, 8'h01, 8'h01, 1'b0},  // R7 carry into high
    '{8'h05, 8'hFE, 8'hFF, 8'd3, 8'h01, 8'h00, 1'b1},  // R7 wrap
    '{8'h04, 8'h1E, 8'h00, 8'd3, 8'h01, 8'h01, 1'b0},  // R6 5-bit carry
    '{8'h04, 8'hFF, 8'hFF, 8'd1, 8'hE0, 8'h00, 1'b1},  // R6 wrap, bits 7:5 kept
    '{8'h06, 8'hFE, 8'hF0, 8'd3, 8'hF1, 8'hF0, 1'b1},  // R8 reload
    '{8'h06, 8'h10, 8'h80, 8'd2, 8'h12, 8'h80, 1'b0}   // R8 no reload
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] sfr_addr;
  logic [7:0] sfr_wdata;
  logic       sfr_we, sfr_re;
  logic [7:0] sfr_rdata;
  logic [1:0] cnt_pin, gate_pin, flag_ack, ovf_irq;
  logic       baud_tick;

  int checks = 0, errors = 0;
  int irq0_n = 0, irq1_n = 0, baud_n = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_tmr_ctr u0 (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .sfr_re(sfr_re), .sfr_rdata(sfr_rdata),
    .cnt_pin(cnt_pin), .gate_pin(gate_pin), .flag_ack(flag_ack),
    .ovf_irq(ovf_irq), .baud_tick(baud_tick)
  );

  always @(negedge clk) begin
    if (ovf_irq[0]) irq0_n++;
    if (ovf_irq[1]) irq1_n++;
    if (baud_tick)  baud_n++;
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic sfr_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic sfr_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_re = 1'b1;
    #1 d = sfr_rdata;
    sfr_re = 1'b0;
  endtask

  task automatic fall0(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); cnt_pin[0] = 1'b1;
      repeat (2) @(negedge clk);
      cnt_pin[0] = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic ack(input logic [1:0] v);
    @(negedge clk); flag_ack = v;
    @(negedge clk); flag_ack = 2'b00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int b0, b1, b2;
    rst_n = 1'b0; sfr_addr = '0; sfr_wdata = '0; sfr_we = 1'b0; sfr_re = 1'b0;
    cnt_pin = '0; gate_pin = '0; flag_ack = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      sfr_rd(3'(a), d); check("R1 reset register", d, 8'h00);
    end
    check("R1 ovf_irq", {6'd0, ovf_irq}, 8'h00);
    check("R1 baud_tick", {7'd0, baud_tick}, 8'h00);

    // R2 map, read-back, read gating
    sfr_wr(A_MODE, 8'hA5); sfr_rd(A_MODE, d); check("R2 mode readback", d, 8'hA5);
    sfr_wr(A_T1H, 8'h3C);  sfr_rd(A_T1H, d);  check("R2 T1 high readback", d, 8'h3C);
    sfr_rd(3'd7, d); check("R2 unused address", d, 8'h00);
    @(negedge clk); sfr_addr = A_MODE; sfr_re = 1'b0; #1 check("R2 re low", sfr_rdata, 8'h00);
    sfr_wr(A_MODE, 8'h00); sfr_wr(A_T1H, 8'h00);

    // vector table: counter source on timer 0
    foreach (VECS[v]) begin
      sfr_wr(A_CTRL, 8'h00);
      sfr_wr(A_MODE, VECS[v].mode);
      sfr_wr(A_T0L, VECS[v].lo);
      sfr_wr(A_T0H, VECS[v].hi);
      b0 = irq0_n;
      sfr_wr(A_CTRL, 8'h01);
      fall0(int'(VECS[v].n));
      repeat (2) @(negedge clk);
      sfr_rd(A_T0L, d);  check("R4 vector low byte", d, VECS[v].elo);
      sfr_rd(A_T0H, d);  check("R4 vector high byte", d, VECS[v].ehi);
      sfr_rd(A_CTRL, d); check("R10 vector flag", d, {6'd0, VECS[v].eflag, 1'b1});
      check("R10 vector irq pulses", 8'(irq0_n - b0), {7'd0, VECS[v].eflag});
    end

    // R3 prescaled source: 120 counted edges give 10 steps
    sfr_wr(A_CTRL, 8'h00);
    sfr_wr(A_MODE, 8'h10);
    sfr_wr(A_T1L, 8'h00); sfr_wr(A_T1H, 8'h00);
    sfr_wr(A_CTRL, 8'h04);
    repeat (118) @(negedge clk);
    sfr_wr(A_CTRL, 8'h00);
    sfr_rd(A_T1L, d); check("R3 prescaled low", d, 8'h0A);
    sfr_rd(A_T1H, d); check("R3 prescaled high", d, 8'h00);

    // R5 gate and run
    sfr_wr(A_MODE, 8'h0D);
    sfr_wr(A_T0L, 8'h00); sfr_wr(A_T0H, 8'h00);
    gate_pin[0] = 1'b0;
    sfr_wr(A_CTRL, 8'h01);
    fall0(3);
    sfr_rd(A_T0L, d); check("R5 gate pin low blocks", d, 8'h00);
    gate_pin[0] = 1'b1; repeat (2) @(negedge clk);
    fall0(2);
    sfr_rd(A_T0L, d); check("R5 gate pin high counts", d, 8'h02);
    sfr_wr(A_CTRL, 8'h00);
    fall0(2);
    sfr_rd(A_T0L, d); check("R5 run clear blocks", d, 8'h02);
    gate_pin[0] = 1'b0;

    // R12 write in the same cycle as a pending edge increment
    sfr_wr(A_MODE, 8'h05);
    sfr_wr(A_T0L, 8'hFF); sfr_wr(A_T0H, 8'h00);
    sfr_wr(A_CTRL, 8'h01);
    @(negedge clk); cnt_pin[0] = 1'b1;
    repeat (2) @(negedge clk);
    cnt_pin[0] = 1'b0;
    @(negedge clk);
    sfr_addr = A_T0L; sfr_wdata = 8'h40; sfr_we = 1'b1;
    @(negedge clk); sfr_we = 1'b0;
    repeat (3) @(negedge clk);
    sfr_rd(A_T0L, d); check("R12 write wins low", d, 8'h40);
    sfr_rd(A_T0H, d); check("R12 no carry high", d, 8'h00);

    // R11 flag clear by ack and by write
    sfr_wr(A_CTRL, 8'h00);
    sfr_wr(A_T0L, 8'hFF); sfr_wr(A_T0H, 8'hFF);
    sfr_wr(A_CTRL, 8'h01);
    fall0(1);
    sfr_rd(A_CTRL, d); check("R10 16-bit wrap sets flag", d, 8'h03);
    sfr_wr(A_CTRL, 8'h0B);
    sfr_rd(A_CTRL, d); check("R11 software sets flags", d, 8'h0B);
    ack(2'b10);
    sfr_rd(A_CTRL, d); check("R11 ack 1 clears only flag 1", d, 8'h03);
    ack(2'b01);
    sfr_rd(A_CTRL, d); check("R11 ack 0 clears flag 0", d, 8'h01);
    sfr_wr(A_CTRL, 8'h0A);
    sfr_wr(A_CTRL, 8'h00);
    sfr_rd(A_CTRL, d); check("R11 write clears flags", d, 8'h00);

    // R9 split mode: high half of timer 0 under run 1, timer 1 frozen
    sfr_wr(A_MODE, 8'h33);
    sfr_wr(A_T1L, 8'h55);
    sfr_wr(A_T0L, 8'h00); sfr_wr(A_T0H, 8'hFF);
    b1 = irq1_n; b2 = baud_n;
    sfr_wr(A_CTRL, 8'h04);
    repeat (14) @(negedge clk);
    sfr_rd(A_CTRL, d); check("R9 split high sets flag 1", d, 8'h0C);
    sfr_rd(A_T0L, d);  check("R9 split low idle without run 0", d, 8'h00);
    sfr_rd(A_T1L, d);  check("R9 timer 1 frozen", d, 8'h55);
    check("R9 irq 1 pulse", 8'(irq1_n - b1), 8'h01);
    check("R9 no baud in split", 8'(baud_n - b2), 8'h00);
    sfr_wr(A_CTRL, 8'h00);
    sfr_wr(A_T0L, 8'h00);
    sfr_wr(A_CTRL, 8'h01);
    repeat (118) @(negedge clk);
    sfr_wr(A_CTRL, 8'h00);
    sfr_rd(A_T0L, d); check("R9 split low prescaled", d, 8'h0A);

    // R10 baud ticks from timer 1 reload mode: 10 steps from FE give 5 overflows
    sfr_wr(A_MODE, 8'h20);
    sfr_wr(A_T1H, 8'hFE); sfr_wr(A_T1L, 8'hFE);
    b1 = irq1_n; b2 = baud_n;
    sfr_wr(A_CTRL, 8'h04);
    repeat (118) @(negedge clk);
    sfr_wr(A_CTRL, 8'h00);
    repeat (3) @(negedge clk);
    check("R10 baud tick count", 8'(baud_n - b2), 8'h05);
    check("R10 irq 1 count", 8'(irq1_n - b1), 8'h05);
    sfr_rd(A_T1L, d); check("R8 reload final low", d, 8'hFE);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule